// File: doc/BRIEF.md
# Dual-Rail Precharge S-Box Slice

This block models a logic style in which every signal travels as a pair of rails, a true rail and a false rail. Only positive cells are used: AND, OR and an AND-OR-INVERT with two 2-input AND terms. Each cell is monotonic, so when all of its input rails are 0, all of its output rails are 0. Inversion is never done by a gate. It is done by exchanging the two rails of a pair.

The block alternates between two phases, one clock cycle each. In the precharge cycle every pair inside the datapath and at the outputs is held at 00. The input registers take new single-rail data on the clock edge that starts the evaluate cycle. They then turn each bit into a rail pair, and exactly one rail of every pair rises. As a result, each evaluation shows the same number of rising rails whatever the data, and no result depends on the one before.

The datapath combines a 4-bit data word with a 4-bit key using dual-rail XOR, which is built from an AND-OR-INVERT cell plus rail swaps. The mixed value is decoded into dual-rail minterms and passed through a 4-bit substitution table. A monitor raises a flag when any internal or output pair shows the forbidden code 11.

Top module: `dr_sbox`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `eval_ph` is 0, `q_t` and `q_f` are all 0, and `illegal` is 0.
- R2: `eval_ph` toggles on every rising clock edge after reset. The value 0 marks a precharge cycle and 1 marks an evaluate cycle.
- R3: In every precharge cycle, every bit of `q_t` and `q_f` is 0, which is pair code 00.
- R4: In every evaluate cycle, each output pair has exactly one rail high: `q_t ^ q_f` is all ones and `q_t & q_f` is zero.
- R5: In an evaluate cycle, `q_t` equals SBOX[`din` XOR `key`] and `q_f` is its complement. Here `din` and `key` are the values sampled on the edge that started that cycle. Pair code 10 means logic 1 and 01 means logic 0. The default table maps indices 0 to 15 onto C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2, with entry j held in bits [4j+3:4j] of the SBOX parameter.
- R6: A change of `din` or `key` during an evaluate cycle has no effect on `q_t` or `q_f` in that cycle.
- R7: `illegal` is 1 only when some internal or output rail pair reads 11, so in normal operation it stays 0 in both phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each cycle is one phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 4 | Single-rail data, sampled on the edge entering evaluate |
| key | input | 4 | Single-rail key, sampled with `din` |
| eval_ph | output | 1 | 1 in an evaluate cycle, 0 in a precharge cycle |
| q_t | output | 4 | True rails of the result pairs |
| q_f | output | 4 | False rails of the result pairs |
| illegal | output | 1 | Some rail pair holds the forbidden code 11 |

## Verification
The bench runs all 256 combinations of data and key. For each one it checks the precharge cycle before the evaluation, the evaluation itself, and a scramble of the inputs halfway through the evaluate cycle. If a cell's false rail were built wrongly, a pair would show 11 or 00 during evaluation and the one-hot rail check would catch it. If the precharge gating were missing, stale values would stay on the rails during the zero wave. If the input register were not held during evaluation, the result would follow the scrambled inputs inside the same cycle.

// File: rtl/dr_sbox.sv
module dr_sbox #(
  parameter int N = 4,
  parameter logic [N*(1<<N)-1:0] SBOX = 64'h2174_8FE3_DA09_B65C
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  input  logic [N-1:0] key,
  output logic         eval_ph,
  output logic [N-1:0] q_t,
  output logic [N-1:0] q_f,
  output logic         illegal
);
  localparam int M = 1 << N;

  typedef struct packed { logic t; logic f; } rail_t;

  function automatic rail_t dr_and(rail_t a, rail_t b);
    rail_t r;
    r.t = a.t & b.t;
    r.f = a.f | b.f;
    return r;
  endfunction

  function automatic rail_t dr_or(rail_t a, rail_t b);
    rail_t r;
    r.t = a.t | b.t;
    r.f = a.f & b.f;
    return r;
  endfunction

  function automatic rail_t dr_not(rail_t a);
    rail_t r;
    r.t = a.f;
    r.f = a.t;
    return r;
  endfunction

  function automatic rail_t dr_aoi22(rail_t a, rail_t b, rail_t c, rail_t d);
    return dr_not(dr_or(dr_and(a, b), dr_and(c, d)));
  endfunction

  function automatic rail_t dr_xor(rail_t a, rail_t b);
    return dr_not(dr_aoi22(a, dr_not(b), dr_not(a), b));
  endfunction

  logic [N-1:0] din_q, key_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eval_ph <= 1'b0;
      din_q   <= '0;
      key_q   <= '0;
    end else begin
      eval_ph <= ~eval_ph;
      if (!eval_ph) begin
        din_q <= din;
        key_q <= key;
      end
    end
  end

  rail_t a [N];
  rail_t k [N];
  rail_t x [N];
  rail_t mt [M];

  for (genvar i = 0; i < N; i++) begin : g_in
    assign a[i].t = eval_ph &  din_q[i];
    assign a[i].f = eval_ph & ~din_q[i];
    assign k[i].t = eval_ph &  key_q[i];
    assign k[i].f = eval_ph & ~key_q[i];
    assign x[i]   = dr_xor(a[i], k[i]);
  end

  for (genvar j = 0; j < M; j++) begin : g_min
    always_comb begin
      rail_t acc;
      acc = ((j & 1) != 0) ? x[0] : dr_not(x[0]);
      for (int b = 1; b < N; b++)
        acc = dr_and(acc, ((j >> b) & 1) != 0 ? x[b] : dr_not(x[b]));
      mt[j] = acc;
    end
  end

  always_comb begin
    q_t = '0;
    q_f = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < M; j++)
        if (SBOX[j*N+i]) q_t[i] = q_t[i] | mt[j].t;
        else             q_f[i] = q_f[i] | mt[j].t;
  end

  always_comb begin
    illegal = |(q_t & q_f);
    for (int i = 0; i < N; i++)
      illegal = illegal | (x[i].t & x[i].f);
    for (int j = 0; j < M; j++)
      illegal = illegal | (mt[j].t & mt[j].f);
  end
endmodule

module dr_sbox_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         eval_ph,
  input logic [N-1:0] q_t,
  input logic [N-1:0] q_f,
  input logic         illegal
);
  assert_phase_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eval_ph |=> !eval_ph);
  assert_phase_resume_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_ph |=> eval_ph);
  assert_precharge_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_ph |-> (q_t == '0 && q_f == '0));
  assert_one_rail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eval_ph |-> ((q_t ^ q_f) == '1 && (q_t & q_f) == '0));
  assert_no_illegal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal);
endmodule

bind dr_sbox dr_sbox_chk #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .eval_ph(eval_ph),
  .q_t(q_t), .q_f(q_f), .illegal(illegal)
);

// File: tb/dr_sbox_tb.sv
module dr_sbox_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] din = '0, key = '0;
  logic       eval_ph, illegal;
  logic [3:0] q_t, q_f;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  logic [3:0] ref_tab [16] = '{4'hC, 4'h5, 4'h6, 4'hB, 4'h9, 4'h0, 4'hA, 4'hD,
                               4'h3, 4'hE, 4'hF, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};

  dr_sbox dut_i (.clk(clk), .rst_n(rst_n), .din(din), .key(key),
                 .eval_ph(eval_ph), .q_t(q_t), .q_f(q_f), .illegal(illegal));

  always #4 clk = ~clk;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", {7'd0, eval_ph, q_t, q_f}, 16'h0);
    chk("R1", {15'd0, illegal}, 16'h0);
    rst_n = 1'b1;
    #1;
    chk("R1", {7'd0, eval_ph, q_t, q_f}, 16'h0);
  endtask

  task automatic t_eval(logic [3:0] d, logic [3:0] k);
    logic [3:0] e;
    e = ref_tab[d ^ k];
    chk("R2", {15'd0, eval_ph}, 16'h0);
    chk("R3", {8'd0, q_t, q_f}, 16'h0);
    chk("R7", {15'd0, illegal}, 16'h0);
    din = d;
    key = k;
    @(posedge clk);
    @(negedge clk);
    chk("R2", {15'd0, eval_ph}, 16'h1);
    chk("R4", {8'd0, q_t ^ q_f, q_t & q_f}, {8'd0, 4'hF, 4'h0});
    chk("R5", {8'd0, q_t, q_f}, {8'd0, e, ~e});
    chk("R7", {15'd0, illegal}, 16'h0);
    din = ~d;
    key = k ^ 4'h5;
    #1;
    chk("R6", {8'd0, q_t, q_f}, {8'd0, e, ~e});
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_sweep();
    for (int kk = 0; kk < 16; kk++)
      for (int dd = 0; dd < 16; dd++)
        t_eval(4'(dd), 4'(kk));
  endtask

  task automatic t_back_to_back();
    t_eval(4'hF, 4'hF);
    t_eval(4'h0, 4'h0);
    t_eval(4'hA, 4'h5);
    t_eval(4'h5, 4'h5);
  endtask

  initial begin
    t_reset();
    t_back_to_back();
    t_sweep();
    t_reset();
    t_eval(4'h3, 4'h9);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule